// File: doc/BRIEF.md
# Unimplemented-Opcode Trap Vector Selector

This block sits in the instruction decode path of a processor that can behave like either of two related machine generations. When the decode strobe is raised, it looks at the 9-bit operation code and decides whether the instruction runs normally, is turned into a no-op, or traps. For a trap it also gives the first address of the two-word trap location pair and tells whether that pair lies in user or executive address space.

The two generations differ in which opcode ranges trap, where they trap to, and which opcodes are silently ignored. The newer generation also has an offset mode that moves every executive trap pair up by octal 100. A user-space pair never moves. The older generation has no such mode and ignores the offset input. The trap itself, saving the PC and fetching the trap instruction belong to the logic downstream of this block.

All results are registered. They appear in the clock cycle after the strobe and last one cycle. In every other cycle all outputs read zero.

Top module: `uvs_trap_sel`

## Requirements
- R1: The outputs for a strobed opcode appear on the rising edge that samples `dec_stb_i`=1 and last one cycle. After a cycle with `dec_stb_i`=0, and during reset, `trap_o`, `nop_o`, `trap_user_o` and `trap_addr_o` are all zero.
- R2: Newer generation (`variant_old_i`=0): opcode 000 and opcodes 040–077 (octal) trap to the executive pair at octal 40, or octal 140 when `offset_mode_i`=1. `trap_user_o` is 0.
- R3: Newer generation: opcodes 001–037 trap to the user pair at octal 40 (`trap_user_o`=1, offset ignored) when `user_mode_i`=1. Otherwise they trap to the executive pair at 40/140 as in R2.
- R4: Newer generation: opcodes 100–127 trap to the executive pair at octal 60, or 160 with offset mode. Opcodes 130–177 run normally.
- R5: Newer generation: opcode 257 gives `nop_o`=1 and no trap.
- R6: Older generation (`variant_old_i`=1): opcodes 040–077 trap to the executive pair at octal 40. Opcodes 000–037, 000 included, trap to the user pair at 40 in user mode and to the executive pair at 40 otherwise.
- R7: Older generation: opcodes 100–117, 131 and 243 give `nop_o`=1. Opcode 257 runs normally.
- R8: Older generation: `offset_mode_i` has no effect on any result.
- R9: Opcodes that no rule covers give `trap_o`=0 and `nop_o`=0, with `trap_addr_o`=0 and `trap_user_o`=0.
- R10: `trap_o` and `nop_o` are never 1 together. Whenever `trap_o`=0, `trap_addr_o` is 0 and `trap_user_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_stb_i | input | 1 | Decode strobe: opcode and flags are valid |
| opcode_i | input | OPC_W (9) | Operation code, value read in octal |
| user_mode_i | input | 1 | 1 = processor in user mode |
| variant_old_i | input | 1 | 1 = older generation rules, 0 = newer |
| offset_mode_i | input | 1 | 1 = move executive pairs up by octal 100 (newer only) |
| trap_o | output | 1 | Trap request, registered |
| trap_addr_o | output | ADDR_W (18) | First address of the trap pair, 0 when no trap |
| trap_user_o | output | 1 | 1 = trap pair is in user space, 0 = executive |
| nop_o | output | 1 | Instruction is to be treated as a no-op |

## Verification
Two things can act in the same cycle: selecting user or executive space from the mode flag, and moving executive pairs by the offset. Both affect opcodes 001–037 of the newer generation. The opcodes in that range must move under offset only when they land in executive space, and must stay at octal 40 when they land in user space. The bench drives every opcode under all eight combinations of generation, user flag and offset flag, with idle strobe-low cycles mixed in. A scoreboard checks each registered result against a model built from the requirements, so each combination of the two effects is judged on its own.

// File: rtl/uvs_pkg.sv
package uvs_pkg;

   // What the decoder decided for one opcode
   typedef enum logic [1:0] {
      ACT_RUN  = 2'd0,
      ACT_TRAP = 2'd1,
      ACT_NOP  = 2'd2
   } uvs_act_e;

   // Result of one rule set, before address generation
   typedef struct packed {
      uvs_act_e act;
      logic     hi_pair;   // 1 = upper executive pair (60/61 family)
      logic     user_sp;   // 1 = pair lives in user space
   } uvs_rule_t;

   localparam uvs_rule_t RULE_RUN = '{act: ACT_RUN, hi_pair: 1'b0, user_sp: 1'b0};

   // Opcodes are compared zero-extended to this width
   localparam int unsigned OPX_W = 16;

   function automatic logic in_rng(logic [OPX_W-1:0] v, int unsigned lo, int unsigned hi);
      return (v >= OPX_W'(lo)) && (v <= OPX_W'(hi));
   endfunction

endpackage

// File: rtl/uvs_rules_new.sv
module uvs_rules_new
   import uvs_pkg::*;
#(
   parameter int unsigned OPC_W   = 9,
   parameter int unsigned IMPL_LO = 'o130  // first implemented opcode in 100..177
) (
   input  logic [OPC_W-1:0] opcode_i,
   input  logic             user_mode_i,
   output uvs_rule_t        rule_o
);

   logic [OPX_W-1:0] op;
   assign op = OPX_W'(opcode_i);

   always_comb begin
      rule_o = RULE_RUN;
      if (op == '0) begin
         // opcode zero always goes to executive space here
         rule_o.act = ACT_TRAP;
      end else if (in_rng(op, 'o1, 'o37)) begin
         rule_o.act     = ACT_TRAP;
         rule_o.user_sp = user_mode_i;
      end else if (in_rng(op, 'o40, 'o77)) begin
         rule_o.act = ACT_TRAP;
      end else if (in_rng(op, 'o100, 'o177)) begin
         if (op < OPX_W'(IMPL_LO)) begin
            rule_o.act     = ACT_TRAP;
            rule_o.hi_pair = 1'b1;
         end
      end else if (op == OPX_W'('o257)) begin
         rule_o.act = ACT_NOP;
      end
   end

endmodule

// File: rtl/uvs_rules_old.sv
module uvs_rules_old
   import uvs_pkg::*;
#(
   parameter int unsigned OPC_W = 9
) (
   input  logic [OPC_W-1:0] opcode_i,
   input  logic             user_mode_i,
   output uvs_rule_t        rule_o
);

   logic [OPX_W-1:0] op;
   logic             is_nop;

   assign op = OPX_W'(opcode_i);

   // opcodes silently ignored by this generation
   assign is_nop = in_rng(op, 'o100, 'o117)
                 || (op == OPX_W'('o131))
                 || (op == OPX_W'('o243));

   always_comb begin
      rule_o = RULE_RUN;
      if (in_rng(op, 'o0, 'o37)) begin
         // zero included: a legal user-space trap
         rule_o.act     = ACT_TRAP;
         rule_o.user_sp = user_mode_i;
      end else if (in_rng(op, 'o40, 'o77)) begin
         rule_o.act = ACT_TRAP;
      end else if (is_nop) begin
         rule_o.act = ACT_NOP;
      end
   end

endmodule

// File: rtl/uvs_addr_gen.sv
module uvs_addr_gen #(
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned LOW_PAIR  = 'o40,
   parameter int unsigned HIGH_PAIR = 'o60,
   parameter int unsigned EXEC_OFS  = 'o100
) (
   input  logic              hi_pair_i,
   input  logic              user_sp_i,
   input  logic              offset_en_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [ADDR_W-1:0] LOW_A  = ADDR_W'(LOW_PAIR);
   localparam logic [ADDR_W-1:0] HIGH_A = ADDR_W'(HIGH_PAIR);
   localparam logic [ADDR_W-1:0] OFS_A  = ADDR_W'(EXEC_OFS);

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] reloc;

   assign base  = hi_pair_i ? HIGH_A : LOW_A;
   // user-space pairs never move
   assign reloc = (offset_en_i && !user_sp_i) ? OFS_A : '0;

   always_comb begin
      if (user_sp_i) addr_o = LOW_A;
      else           addr_o = base + reloc;
   end

endmodule

// File: rtl/uvs_trap_sel.sv
module uvs_trap_sel
   import uvs_pkg::*;
#(
   parameter int unsigned OPC_W       = 9,
   parameter int unsigned ADDR_W      = 18,
   parameter int unsigned LOW_PAIR    = 'o40,
   parameter int unsigned HIGH_PAIR   = 'o60,
   parameter int unsigned EXEC_OFS    = 'o100,
   parameter int unsigned IMPL_LO     = 'o130,
   parameter bit          SUPPORT_OLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_stb_i,
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic              user_mode_i,
   input  logic              variant_old_i,
   input  logic              offset_mode_i,
   output logic              trap_o,
   output logic [ADDR_W-1:0] trap_addr_o,
   output logic              trap_user_o,
   output logic              nop_o
);

   localparam longint unsigned TOP_ADDR = longint'(HIGH_PAIR) + longint'(EXEC_OFS) + 1;

   // elaboration-time parameter checks
   if (OPC_W < 9 || OPC_W > OPX_W) begin : g_bad_opc_w
      $error("uvs_trap_sel: OPC_W must lie in 9..16");
   end
   if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_addr_w
      $error("uvs_trap_sel: ADDR_W must lie in 2..31");
   end
   if (TOP_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_fit
      $error("uvs_trap_sel: relocated trap pair does not fit in ADDR_W");
   end
   if (LOW_PAIR[0] || HIGH_PAIR[0]) begin : g_bad_even
      $error("uvs_trap_sel: trap pairs must start on an even address");
   end
   if (IMPL_LO < 'o100 || IMPL_LO > 'o200) begin : g_bad_impl
      $error("uvs_trap_sel: IMPL_LO must lie in 100..200 octal");
   end

   uvs_rule_t         new_rule;
   uvs_rule_t         old_rule;
   uvs_rule_t         sel_rule;
   logic              use_old;
   logic              offset_en;
   logic [ADDR_W-1:0] vec_addr;

   uvs_rules_new #(
      .OPC_W   (OPC_W),
      .IMPL_LO (IMPL_LO)
   ) u_rules_new (
      .opcode_i    (opcode_i),
      .user_mode_i (user_mode_i),
      .rule_o      (new_rule)
   );

   if (SUPPORT_OLD) begin : g_old
      uvs_rules_old #(
         .OPC_W (OPC_W)
      ) u_rules_old (
         .opcode_i    (opcode_i),
         .user_mode_i (user_mode_i),
         .rule_o      (old_rule)
      );
      assign use_old = variant_old_i;
   end else begin : g_new_only
      assign old_rule = RULE_RUN;
      assign use_old  = 1'b0;
   end

   assign sel_rule  = use_old ? old_rule : new_rule;
   // the older generation has no relocation mode
   assign offset_en = offset_mode_i && !use_old;

   uvs_addr_gen #(
      .ADDR_W    (ADDR_W),
      .LOW_PAIR  (LOW_PAIR),
      .HIGH_PAIR (HIGH_PAIR),
      .EXEC_OFS  (EXEC_OFS)
   ) u_addr_gen (
      .hi_pair_i   (sel_rule.hi_pair),
      .user_sp_i   (sel_rule.user_sp),
      .offset_en_i (offset_en),
      .addr_o      (vec_addr)
   );

   // result register: one-cycle pulse per strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_o      <= 1'b0;
         nop_o       <= 1'b0;
         trap_user_o <= 1'b0;
         trap_addr_o <= '0;
      end else if (dec_stb_i && sel_rule.act == ACT_TRAP) begin
         trap_o      <= 1'b1;
         nop_o       <= 1'b0;
         trap_user_o <= sel_rule.user_sp;
         trap_addr_o <= vec_addr;
      end else begin
         trap_o      <= 1'b0;
         nop_o       <= dec_stb_i && (sel_rule.act == ACT_NOP);
         trap_user_o <= 1'b0;
         trap_addr_o <= '0;
      end
   end

   // R10
   trap_nop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_o && nop_o));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(dec_stb_i) |-> (!trap_o && !nop_o && !trap_user_o));

   // R10
   no_trap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_o |-> (trap_addr_o == '0 && !trap_user_o));

   // R3
   user_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_user_o |-> ($past(user_mode_i) && trap_addr_o == ADDR_W'(LOW_PAIR)));

   // R2
   pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> !trap_addr_o[0]);

   if (SUPPORT_OLD) begin : g_old_chk
      // R8
      old_no_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (trap_o && $past(variant_old_i)) |-> (trap_addr_o < ADDR_W'(EXEC_OFS)));
   end

endmodule

// File: tb/tb_uvs_trap_sel.sv
module tb_uvs_trap_sel;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 18;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dec_stb = 1'b0;
   logic [8:0]        opc = '0;
   logic              user_m = 1'b0;
   logic              var_old = 1'b0;
   logic              ofs = 1'b0;
   logic              trap;
   logic [ADDR_W-1:0] taddr;
   logic              tuser;
   logic              nop;

   always #(CLK_PERIOD/2) clk = ~clk;

   uvs_trap_sel dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .dec_stb_i     (dec_stb),
      .opcode_i      (opc),
      .user_mode_i   (user_m),
      .variant_old_i (var_old),
      .offset_mode_i (ofs),
      .trap_o        (trap),
      .trap_addr_o   (taddr),
      .trap_user_o   (tuser),
      .nop_o         (nop)
   );

   typedef struct {
      bit    trap;
      bit    nop;
      bit    usr;
      int    addr;
      string tag;
      int    op;
   } exp_t;

   exp_t sbq[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   // expectation built from the requirement list
   function automatic exp_t model(bit stb, int op, bit old, bit um, bit of);
      exp_t e;
      e.trap = 0; e.nop = 0; e.usr = 0; e.addr = 0; e.op = op; e.tag = "R9";
      if (!stb) begin
         e.tag = "R1";
      end else if (!old) begin
         if (op == 0 || (op >= 'o40 && op <= 'o77)) begin
            e.trap = 1; e.addr = of ? 'o140 : 'o40; e.tag = "R2";
         end else if (op >= 'o1 && op <= 'o37) begin
            e.trap = 1; e.tag = "R3";
            if (um) begin e.usr = 1; e.addr = 'o40; end
            else e.addr = of ? 'o140 : 'o40;
         end else if (op >= 'o100 && op <= 'o127) begin
            e.trap = 1; e.addr = of ? 'o160 : 'o60; e.tag = "R4";
         end else if (op >= 'o130 && op <= 'o177) begin
            e.tag = "R4";
         end else if (op == 'o257) begin
            e.nop = 1; e.tag = "R5";
         end
      end else begin
         if (op <= 'o77) begin
            e.trap = 1; e.addr = 'o40; e.tag = of ? "R8" : "R6";
            if (op <= 'o37 && um) e.usr = 1;
         end else if ((op >= 'o100 && op <= 'o117) || op == 'o131 || op == 'o243) begin
            e.nop = 1; e.tag = "R7";
         end else if (op == 'o257) begin
            e.tag = "R7";
         end
      end
      return e;
   endfunction

   // driver: presents one cycle of stimulus and queues its expectation
   task automatic drive(bit stb, int op, bit old, bit um, bit of);
      @(negedge clk);
      dec_stb = stb;
      opc     = 9'(op);
      var_old = old;
      user_m  = um;
      ofs     = of;
      sbq.push_back(model(stb, op, old, um, of));
   endtask

   // monitor: result of the previous negedge stimulus is registered at this edge
   always @(posedge clk) begin
      exp_t e;
      if (rst_n && sbq.size() > 0) begin
         #1;
         e = sbq.pop_front();
         n_cmp++;
         if (trap !== e.trap || nop !== e.nop || tuser !== e.usr || int'(taddr) !== e.addr) begin
            n_bad++;
            $display("FAIL %s op=%o: actual trap=%0b nop=%0b user=%0b addr=%o expected trap=%0b nop=%0b user=%0b addr=%o",
                     e.tag, e.op, trap, nop, tuser, taddr, e.trap, e.nop, e.usr, e.addr);
         end
         n_cmp++;
         if (trap && nop) begin
            n_bad++;
            $display("FAIL R10 op=%o: actual trap=1 nop=1 expected at most one set", e.op);
         end
      end
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: quiet during reset
      n_cmp++;
      if (trap !== 0 || nop !== 0 || tuser !== 0 || taddr !== '0) begin
         n_bad++;
         $display("FAIL R1 reset: actual trap=%0b nop=%0b user=%0b addr=%o expected all zero",
                  trap, nop, tuser, taddr);
      end
      rst_n = 1'b1;
      for (int v = 0; v < 2; v++) begin
         for (int u = 0; u < 2; u++) begin
            for (int f = 0; f < 2; f++) begin
               for (int op = 0; op < 512; op++) begin
                  drive(1'b1, op, v[0], u[0], f[0]);
                  // R1: an unstrobed trap opcode between strobes must stay silent
                  if (op % 61 == 7) drive(1'b0, 'o41, v[0], u[0], f[0]);
               end
            end
         end
      end
      drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
      drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
      while (sbq.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog: actual run still busy expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule